// File: doc/BRIEF.md
# Memory-Mapped Register Window Bridge

This block sits between a host that issues reads and writes into a 4 KiB register window and two downstream register buses of a display controller. It decodes the window into three sub-windows and turns each host access into a short, ordered series of downstream operations. The first sub-window is an alias of a 32-byte range of the legacy byte-wide display ports. The second reaches a bank of 16-bit registers that sit behind an index/data pair. The third is an optional bank of two 32-bit words: one reports the size of the bank, and one selects the byte order of the framebuffer.

The host holds a request (valid, write, address, size code, write data) steady until the bridge returns a one-cycle ready pulse with the read data. Accesses wider than the downstream bus are split into ordered sub-operations, and the lower address always goes first. For the indexed bank, each 16-bit transfer is an index load taken from the address, followed by the data access. A revision output tells software whether the extension bank is present.

Top module: `mmio_window_bridge`

## Requirements
- R1: After reset, req_ready, port_en and ix_en are low, fb_big_endian is low (little-endian), and a later read of extension offset 4 returns 0x1E1E1E1E.
- R2: A byte access (req_size=0) at window offset 0x400+k, k<32, performs one port operation at port address 0x3C0+k. A write sends req_wdata[7:0]. A read returns the port byte in req_rdata[7:0], with the upper bits zero.
- R3: A 16-bit access (req_size=1) at legacy offset N performs two port operations. The first goes to port N and carries data bits 7:0. The second goes to port N+1 and carries bits 15:8. A read returns port N in bits 7:0 and port N+1 in bits 15:8.
- R4: A 32-bit access (req_size=2) at legacy offset N performs four port operations at ports N, N+1, N+2 and N+3, in that order. Byte k of the data maps to bits 8k+7:8k.
- R5: A byte or 16-bit access at offset 0x500+j, j<0x16, performs an index write (ix_sel=0, ix_we=1, value j>>1) and then one data operation (ix_sel=1). A write sends req_wdata[15:0]. A read returns the register value in req_rdata[15:0].
- R6: A 32-bit access to the indexed bank performs two index-then-data pairs. The first uses index j>>1 and carries data bits 15:0. The second uses index (j>>1)+1 and carries bits 31:16.
- R7: With ext_en high, a 32-bit read of offset 0x600 returns 8.
- R8: With ext_en high, a 32-bit read of offset 0x604 returns 0xBEBEBEBE when fb_big_endian is high and 0x1E1E1E1E when it is low. A 32-bit write of exactly 0xBEBEBEBE there sets fb_big_endian. A write of exactly 0x1E1E1E1E clears it. Any other value leaves it unchanged.
- R9: Within offsets 0x600-0x607, the following read zero and have no effect on fb_big_endian: every offset other than 0 and 4, every access that is not 32 bits, and every access while ext_en is low.
- R10: An access outside all enabled sub-windows, or one with the reserved size code 3, returns zero, produces no downstream operation, and still completes with a ready pulse.
- R11: rev_id reads 2 while ext_en is high and 1 while it is low, one cycle after ext_en settles.
- R12: req_ready is high for exactly one cycle per request. Each downstream strobe (port_en, ix_en) is high for one cycle per operation. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables the extension bank |
| req_valid | input | 1 | Host request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| req_wdata | input | 32 | Host write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| port_en | output | 1 | Legacy port operation strobe |
| port_we | output | 1 | Legacy port write |
| port_addr | output | 10 | Legacy port address |
| port_wdata | output | 8 | Legacy port write byte |
| port_rdata | input | 8 | Legacy port read byte, same cycle as port_en |
| ix_en | output | 1 | Indexed bus operation strobe |
| ix_sel | output | 1 | 0 = index register, 1 = data register |
| ix_we | output | 1 | Indexed bus write |
| ix_wdata | output | 16 | Index value or data word |
| ix_rdata | input | 16 | Data register read value, same cycle as ix_en |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| rev_id | output | 8 | Revision value |

## Verification
The bench builds the bridge with its default parameters: a 12-bit window address, a 32-byte legacy alias at 0x400, an 11-register indexed bank at 0x500, an 8-byte extension bank at 0x600 and a 16-bit indexed bus. With these values the bench can reach every sub-window, the gaps between them and the top of the window. It toggles ext_en at run time, so the same extension address is exercised both decoded and undecoded. The bench models the downstream ports and the indexed register file itself. A scoreboard checks the exact order of index loads, byte lanes and port addresses for every access width.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_LEG  = 2'd1,
    RG_IDX  = 2'd2,
    RG_EXT  = 2'd3
  } region_e;

  localparam logic [31:0] ORDER_BIG    = 32'hBEBE_BEBE;
  localparam logic [31:0] ORDER_LITTLE = 32'h1E1E_1E1E;
endpackage

// File: rtl/mwb_decode.sv
module mwb_decode
  import mwb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int LEG_BASE = 'h400,
  parameter int LEG_SPAN = 'h20,
  parameter int IDX_BASE = 'h500,
  parameter int IDX_SPAN = 'h16,
  parameter int EXT_BASE = 'h600,
  parameter int EXT_SPAN = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              ext_en,
  output region_e           region,
  output logic [ADDR_W-1:0] off,
  output logic [2:0]        nsteps
);
  localparam logic [ADDR_W:0] LEG_LO = (ADDR_W+1)'(LEG_BASE);
  localparam logic [ADDR_W:0] LEG_HI = (ADDR_W+1)'(LEG_BASE + LEG_SPAN);
  localparam logic [ADDR_W:0] IDX_LO = (ADDR_W+1)'(IDX_BASE);
  localparam logic [ADDR_W:0] IDX_HI = (ADDR_W+1)'(IDX_BASE + IDX_SPAN);
  localparam logic [ADDR_W:0] EXT_LO = (ADDR_W+1)'(EXT_BASE);
  localparam logic [ADDR_W:0] EXT_HI = (ADDR_W+1)'(EXT_BASE + EXT_SPAN);

  logic [ADDR_W:0] a;
  assign a = {1'b0, addr};

  always_comb begin
    region = RG_NONE;
    off    = '0;
    nsteps = 3'd0;
    if (size != SZ_RSVD) begin
      if (a >= LEG_LO && a < LEG_HI) begin
        region = RG_LEG;
        off    = addr - ADDR_W'(LEG_BASE);
        case (size)
          SZ_BYTE: nsteps = 3'd1;
          SZ_HALF: nsteps = 3'd2;
          default: nsteps = 3'd4;
        endcase
      end else if (a >= IDX_LO && a < IDX_HI) begin
        region = RG_IDX;
        off    = addr - ADDR_W'(IDX_BASE);
        nsteps = (size == SZ_WORD) ? 3'd4 : 3'd2;
      end else if (ext_en && a >= EXT_LO && a < EXT_HI) begin
        region = RG_EXT;
        off    = addr - ADDR_W'(EXT_BASE);
      end
    end
  end
endmodule

// File: rtl/mwb_ext_bank.sv
module mwb_ext_bank
  import mwb_pkg::*;
#(
  parameter int EXT_SPAN = 8,
  localparam int OFF_W = $clog2(EXT_SPAN),
  localparam logic [OFF_W-1:0] SLOT_SIZE  = OFF_W'(0),
  localparam logic [OFF_W-1:0] SLOT_ORDER = OFF_W'(4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] off,
  input  logic             size_ok,
  input  logic             we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             big_endian
);
  logic big_q;
  assign big_endian = big_q;

  always_comb begin
    rdata = '0;
    if (size_ok) begin
      if (off == SLOT_SIZE)       rdata = 32'(EXT_SPAN);
      else if (off == SLOT_ORDER) rdata = big_q ? ORDER_BIG : ORDER_LITTLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      big_q <= 1'b0;
    end else if (we && size_ok && off == SLOT_ORDER) begin
      if (wdata == ORDER_BIG)         big_q <= 1'b1;
      else if (wdata == ORDER_LITTLE) big_q <= 1'b0;
    end
  end

  // R8: the flag moves only after a full-word write to the order slot
  a_r8_flag_only_on_order_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(big_q) |-> $past(we && size_ok && off == SLOT_ORDER));
  // R8: a big-endian magic write is honoured
  a_r8_big_magic_sets: assert property (@(posedge clk) disable iff (rst)
    (we && size_ok && off == SLOT_ORDER && wdata == ORDER_BIG) |=> big_q);
endmodule

// File: rtl/mwb_seq.sv
module mwb_seq
  import mwb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int IX_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  region_e           region,
  input  logic [ADDR_W-1:0] off,
  input  logic [2:0]        nsteps,
  input  logic [31:0]       ext_rdata,
  output logic              ext_we,
  output logic              req_ready,
  output logic [31:0]       req_rdata,
  output logic              port_en,
  output logic              port_we,
  output logic [PORT_W-1:0] port_addr,
  output logic [7:0]        port_wdata,
  input  logic [7:0]        port_rdata,
  output logic              ix_en,
  output logic              ix_sel,
  output logic              ix_we,
  output logic [IX_W-1:0]   ix_wdata,
  input  logic [IX_W-1:0]   ix_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e            st;
  logic              wr_q;
  logic [31:0]       wdata_q;
  region_e           region_q;
  logic [ADDR_W-1:0] off_q;
  logic [2:0]        nsteps_q;
  logic [2:0]        step_q;
  logic [31:0]       acc_q, acc_nx;
  logic              accept, last_step;

  assign accept    = (st == S_IDLE) && req_valid && !req_ready;
  assign ext_we    = accept && req_write && (region == RG_EXT);
  assign last_step = (step_q == nsteps_q - 3'd1);

  always_comb begin
    acc_nx = acc_q;
    if (!wr_q) begin
      if (region_q == RG_LEG)
        acc_nx[{step_q[1:0], 3'b000} +: 8] = port_rdata;
      else if (region_q == RG_IDX && step_q[0])
        acc_nx[{step_q[1], 4'b0000} +: 16] = ix_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      region_q   <= RG_NONE;
      off_q      <= '0;
      nsteps_q   <= '0;
      step_q     <= '0;
      acc_q      <= '0;
      req_ready  <= 1'b0;
      req_rdata  <= '0;
      port_en    <= 1'b0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
      ix_en      <= 1'b0;
      ix_sel     <= 1'b0;
      ix_we      <= 1'b0;
      ix_wdata   <= '0;
    end else begin
      req_ready <= 1'b0;
      port_en   <= 1'b0;
      ix_en     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (region == RG_LEG || region == RG_IDX) begin
              wr_q     <= req_write;
              wdata_q  <= req_wdata;
              region_q <= region;
              off_q    <= off;
              nsteps_q <= nsteps;
              step_q   <= '0;
              acc_q    <= '0;
              st       <= S_ISSUE;
            end else begin
              req_ready <= 1'b1;
              req_rdata <= (region == RG_EXT && !req_write) ? ext_rdata : '0;
            end
          end
        end
        S_ISSUE: begin
          if (region_q == RG_LEG) begin
            port_en    <= 1'b1;
            port_we    <= wr_q;
            port_addr  <= PORT_W'(PORT_BASE) + PORT_W'(off_q) + PORT_W'(step_q);
            port_wdata <= wdata_q[{step_q[1:0], 3'b000} +: 8];
          end else begin
            ix_en <= 1'b1;
            if (!step_q[0]) begin
              ix_sel   <= 1'b0;
              ix_we    <= 1'b1;
              ix_wdata <= IX_W'(off_q >> 1) + IX_W'(step_q[1]);
            end else begin
              ix_sel   <= 1'b1;
              ix_we    <= wr_q;
              ix_wdata <= wdata_q[{step_q[1], 4'b0000} +: 16];
            end
          end
          st <= S_WAIT;
        end
        default: begin
          acc_q <= acc_nx;
          if (last_step) begin
            req_ready <= 1'b1;
            req_rdata <= acc_nx;
            st        <= S_IDLE;
          end else begin
            step_q <= step_q + 3'd1;
            st     <= S_ISSUE;
          end
        end
      endcase
    end
  end

  // R12: completion is a single-cycle pulse
  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
  // R12: the two downstream buses never operate together
  a_r12_one_bus: assert property (@(posedge clk) disable iff (rst)
    !(port_en && ix_en));
  // R12: each port strobe lasts one cycle
  a_r12_port_strobe_once: assert property (@(posedge clk) disable iff (rst)
    port_en |=> !port_en);
  // R5: a data-register operation always follows an index load
  a_r5_index_before_data: assert property (@(posedge clk) disable iff (rst)
    (ix_en && ix_sel) |-> $past(ix_en && !ix_sel, 2));
  // R4: port operations within one access climb by one address
  a_r4_ports_ascend: assert property (@(posedge clk) disable iff (rst)
    (port_en && $past(port_en, 2)) |-> port_addr == $past(port_addr, 2) + PORT_W'(1));
endmodule

// File: rtl/mmio_window_bridge.sv
module mmio_window_bridge
  import mwb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int IDX_BASE  = 'h500,
  parameter int IDX_SPAN  = 'h16,
  parameter int EXT_BASE  = 'h600,
  parameter int EXT_SPAN  = 8,
  parameter int PORT_W    = 10,
  parameter int PORT_BASE = 'h3C0,
  parameter int IX_W      = 16,
  parameter int REV_PLAIN = 1,
  parameter int REV_EXT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic [31:0]       req_rdata,
  output logic              port_en,
  output logic              port_we,
  output logic [PORT_W-1:0] port_addr,
  output logic [7:0]        port_wdata,
  input  logic [7:0]        port_rdata,
  output logic              ix_en,
  output logic              ix_sel,
  output logic              ix_we,
  output logic [IX_W-1:0]   ix_wdata,
  input  logic [IX_W-1:0]   ix_rdata,
  output logic              fb_big_endian,
  output logic [7:0]        rev_id
);
  localparam int EXT_OFF_W = $clog2(EXT_SPAN);

  region_e           region;
  logic [ADDR_W-1:0] off;
  logic [2:0]        nsteps;
  logic [31:0]       ext_rdata;
  logic              ext_we;
  acc_size_e         size_e;

  assign size_e = acc_size_e'(req_size);

  mwb_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
    .IDX_BASE(IDX_BASE), .IDX_SPAN(IDX_SPAN),
    .EXT_BASE(EXT_BASE), .EXT_SPAN(EXT_SPAN)
  ) u_decode (
    .addr(req_addr), .size(size_e), .ext_en(ext_en),
    .region(region), .off(off), .nsteps(nsteps)
  );

  mwb_ext_bank #(.EXT_SPAN(EXT_SPAN)) u_ext (
    .clk(clk), .rst(rst),
    .off(off[EXT_OFF_W-1:0]),
    .size_ok(size_e == SZ_WORD),
    .we(ext_we), .wdata(req_wdata),
    .rdata(ext_rdata), .big_endian(fb_big_endian)
  );

  mwb_seq #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PORT_BASE(PORT_BASE), .IX_W(IX_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .region(region), .off(off), .nsteps(nsteps),
    .ext_rdata(ext_rdata), .ext_we(ext_we),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .ix_en(ix_en), .ix_sel(ix_sel), .ix_we(ix_we),
    .ix_wdata(ix_wdata), .ix_rdata(ix_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rev_id <= 8'(REV_PLAIN);
    else     rev_id <= ext_en ? 8'(REV_EXT) : 8'(REV_PLAIN);
  end

  // R11: revision follows the extension enable one cycle later
  a_r11_rev_tracks_enable: assert property (@(posedge clk) disable iff (rst)
    $past(ext_en) |-> rev_id == 8'(REV_EXT));
  // R10: no downstream activity while the host has nothing pending
  a_r10_quiet_without_request: assert property (@(posedge clk) disable iff (rst)
    ($past(!req_valid, 1) && $past(!req_valid, 2) && $past(!req_valid, 3)) |-> !(port_en || ix_en));
endmodule

// File: tb/mmio_window_bridge_tb.sv
module mmio_window_bridge_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        ext_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        port_en, port_we;
  logic [9:0]  port_addr;
  logic [7:0]  port_wdata, port_rdata;
  logic        ix_en, ix_sel, ix_we;
  logic [15:0] ix_wdata, ix_rdata;
  logic        fb_big_endian;
  logic [7:0]  rev_id;

  mmio_window_bridge dut_i (
    .clk(clk), .rst(rst), .ext_en(ext_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .ix_en(ix_en), .ix_sel(ix_sel), .ix_we(ix_we),
    .ix_wdata(ix_wdata), .ix_rdata(ix_rdata),
    .fb_big_endian(fb_big_endian), .rev_id(rev_id)
  );

  // downstream device models
  logic [7:0]  pmem  [0:31];
  logic [15:0] iregs [0:15];
  logic [15:0] cur_idx = '0;
  assign port_rdata = pmem[port_addr[4:0]];
  assign ix_rdata   = iregs[cur_idx[3:0]];

  always @(posedge clk) begin
    if (port_en && port_we) pmem[port_addr[4:0]] <= port_wdata;
    if (ix_en && ix_we) begin
      if (!ix_sel) cur_idx <= ix_wdata;
      else         iregs[cur_idx[3:0]] <= ix_wdata;
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // scoreboard of downstream operations: {bus, we, sel, addr[9:0], data[15:0]}
  logic [28:0] exp_q[$];
  string       tag_q[$];

  task automatic exp_port(input bit we, input logic [9:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({1'b0, we, 1'b0, a, we ? {8'h00, d} : 16'h0000});
    tag_q.push_back(tag);
  endtask

  task automatic exp_ix(input bit we, input bit sel, input logic [15:0] d, input string tag);
    exp_q.push_back({1'b1, we, sel, 10'h000, we ? d : 16'h0000});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && (port_en || ix_en)) begin
      logic [28:0] act;
      if (port_en) act = {1'b0, port_we, 1'b0, port_addr, port_we ? {8'h00, port_wdata} : 16'h0000};
      else         act = {1'b1, ix_we, ix_sel, 10'h000, ix_we ? ix_wdata : 16'h0000};
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected downstream op", {3'b0, act}, 32'h0);
      end else begin
        logic [28:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, {3'b0, act}, {3'b0, e});
      end
      check(!(port_en && ix_en), "R12 both strobes", {30'b0, port_en, ix_en}, 32'h0);
    end
  end

  task automatic do_req(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int waited;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!req_ready && waited < 60);
    if (!req_ready) check(1'b0, "R12 watchdog: no ready", 32'h0, 32'h1);
    rd = req_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R12 ready single cycle", {31'b0, req_ready}, 32'h0);
  endtask

  logic [31:0] rd, expv;

  initial begin
    for (int k = 0; k < 32; k++) pmem[k] = 8'(k * 7 + 8'h11);
    for (int k = 0; k < 16; k++) iregs[k] = 16'(16'hA000 + k * 16'h0111);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b0, "R1 ready in reset", {31'b0, req_ready}, 32'h0);
    check(!port_en && !ix_en, "R1 strobes in reset", {30'b0, port_en, ix_en}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(fb_big_endian == 1'b0, "R1 byte order after reset", {31'b0, fb_big_endian}, 32'h0);
    check(rev_id == 8'd1, "R11 rev with ext off", {24'b0, rev_id}, 32'd1);
    ext_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rev_id == 8'd2, "R11 rev with ext on", {24'b0, rev_id}, 32'd2);
    do_req(0, 12'h604, 2'd2, 0, rd);
    check(rd == 32'h1E1E1E1E, "R1 order read after reset", rd, 32'h1E1E1E1E);

    // R2 byte access
    exp_port(1, 10'h3C5, 8'h5A, "R2 byte write op");
    do_req(1, 12'h405, 2'd0, 32'hFFFF_FF5A, rd);
    exp_port(0, 10'h3C5, 0, "R2 byte read op");
    do_req(0, 12'h405, 2'd0, 0, rd);
    check(rd == 32'h0000005A, "R2 byte read data", rd, 32'h5A);
    expv = {24'h0, pmem[31]};
    exp_port(0, 10'h3DF, 0, "R2 top port read op");
    do_req(0, 12'h41F, 2'd0, 0, rd);
    check(rd == expv, "R2 top port read data", rd, expv);

    // R3 16-bit access, low byte first
    exp_port(1, 10'h3D4, 8'h44, "R3 low byte first");
    exp_port(1, 10'h3D5, 8'h33, "R3 high byte second");
    do_req(1, 12'h414, 2'd1, 32'h0000_3344, rd);
    exp_port(0, 10'h3D4, 0, "R3 read low op");
    exp_port(0, 10'h3D5, 0, "R3 read high op");
    do_req(0, 12'h414, 2'd1, 0, rd);
    check(rd == 32'h00003344, "R3 half read data", rd, 32'h3344);

    // R4 32-bit access
    expv = {pmem[3], pmem[2], pmem[1], pmem[0]};
    for (int k = 0; k < 4; k++) exp_port(0, 10'(10'h3C0 + k), 0, "R4 word read op order");
    do_req(0, 12'h400, 2'd2, 0, rd);
    check(rd == expv, "R4 word read data", rd, expv);
    exp_port(1, 10'h3C8, 8'hEF, "R4 write byte0");
    exp_port(1, 10'h3C9, 8'hBE, "R4 write byte1");
    exp_port(1, 10'h3CA, 8'hAD, "R4 write byte2");
    exp_port(1, 10'h3CB, 8'hDE, "R4 write byte3");
    do_req(1, 12'h408, 2'd2, 32'hDEADBEEF, rd);
    for (int k = 0; k < 4; k++) exp_port(0, 10'(10'h3C8 + k), 0, "R4 readback op");
    do_req(0, 12'h408, 2'd2, 0, rd);
    check(rd == 32'hDEADBEEF, "R4 word readback", rd, 32'hDEADBEEF);

    // R5 indexed 16-bit access
    exp_ix(1, 0, 16'd3, "R5 index load");
    exp_ix(1, 1, 16'h1234, "R5 data write");
    do_req(1, 12'h506, 2'd1, 32'h5555_1234, rd);
    exp_ix(1, 0, 16'd3, "R5 index load for read");
    exp_ix(0, 1, 0, "R5 data read");
    do_req(0, 12'h506, 2'd1, 0, rd);
    check(rd == 32'h00001234, "R5 indexed read data", rd, 32'h1234);
    exp_ix(1, 0, 16'd1, "R5 byte index load");
    exp_ix(1, 1, 16'h0077, "R5 byte data write");
    do_req(1, 12'h503, 2'd0, 32'h0000_0077, rd);
    exp_ix(1, 0, 16'd10, "R5 last register index");
    exp_ix(0, 1, 0, "R5 last register read");
    expv = {16'h0, iregs[10]};
    do_req(0, 12'h514, 2'd1, 0, rd);
    check(rd == expv, "R5 last register data", rd, expv);

    // R6 indexed 32-bit access
    expv = {iregs[9], iregs[8]};
    exp_ix(1, 0, 16'd8, "R6 first index");
    exp_ix(0, 1, 0, "R6 first data");
    exp_ix(1, 0, 16'd9, "R6 second index");
    exp_ix(0, 1, 0, "R6 second data");
    do_req(0, 12'h510, 2'd2, 0, rd);
    check(rd == expv, "R6 word read data", rd, expv);
    exp_ix(1, 0, 16'd0, "R6 write first index");
    exp_ix(1, 1, 16'hF00D, "R6 write lower half");
    exp_ix(1, 0, 16'd1, "R6 write second index");
    exp_ix(1, 1, 16'hCAFE, "R6 write upper half");
    do_req(1, 12'h500, 2'd2, 32'hCAFEF00D, rd);

    // R7, R8 extension bank
    do_req(0, 12'h600, 2'd2, 0, rd);
    check(rd == 32'd8, "R7 size register", rd, 32'd8);
    do_req(1, 12'h604, 2'd2, 32'h12345678, rd);
    @(negedge clk);
    check(fb_big_endian == 1'b0, "R8 non-magic write ignored", {31'b0, fb_big_endian}, 32'h0);
    do_req(1, 12'h604, 2'd2, 32'hBEBEBEBE, rd);
    check(fb_big_endian == 1'b1, "R8 big magic sets flag", {31'b0, fb_big_endian}, 32'h1);
    do_req(0, 12'h604, 2'd2, 0, rd);
    check(rd == 32'hBEBEBEBE, "R8 order reads big", rd, 32'hBEBEBEBE);
    do_req(1, 12'h604, 2'd2, 32'hBEBEBEBF, rd);
    check(fb_big_endian == 1'b1, "R8 near-magic write ignored", {31'b0, fb_big_endian}, 32'h1);
    do_req(1, 12'h604, 2'd2, 32'h1E1E1E1E, rd);
    check(fb_big_endian == 1'b0, "R8 little magic clears flag", {31'b0, fb_big_endian}, 32'h0);

    // R9 extension corners
    do_req(0, 12'h602, 2'd2, 0, rd);
    check(rd == 32'h0, "R9 other offset reads zero", rd, 32'h0);
    do_req(0, 12'h600, 2'd0, 0, rd);
    check(rd == 32'h0, "R9 byte access reads zero", rd, 32'h0);
    do_req(1, 12'h604, 2'd1, 32'hBEBEBEBE, rd);
    check(fb_big_endian == 1'b0, "R9 half write ignored", {31'b0, fb_big_endian}, 32'h0);
    do_req(1, 12'h600, 2'd2, 32'hBEBEBEBE, rd);
    check(fb_big_endian == 1'b0, "R9 magic at size slot ignored", {31'b0, fb_big_endian}, 32'h0);
    ext_en = 1'b0;
    do_req(0, 12'h600, 2'd2, 0, rd);
    check(rd == 32'h0, "R9 disabled bank reads zero", rd, 32'h0);
    do_req(1, 12'h604, 2'd2, 32'hBEBEBEBE, rd);
    check(fb_big_endian == 1'b0, "R9 disabled bank write dropped", {31'b0, fb_big_endian}, 32'h0);
    check(rev_id == 8'd1, "R11 rev back to plain", {24'b0, rev_id}, 32'd1);

    // R10 outside windows and reserved size
    do_req(0, 12'h000, 2'd2, 0, rd);
    check(rd == 32'h0, "R10 low gap reads zero", rd, 32'h0);
    do_req(0, 12'h516, 2'd1, 0, rd);
    check(rd == 32'h0, "R10 past indexed bank reads zero", rd, 32'h0);
    do_req(1, 12'h420, 2'd0, 32'hFF, rd);
    do_req(0, 12'hFFC, 2'd2, 0, rd);
    check(rd == 32'h0, "R10 window top reads zero", rd, 32'h0);
    do_req(0, 12'h404, 2'd3, 0, rd);
    check(rd == 32'h0, "R10 reserved size reads zero", rd, 32'h0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R12 global watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule